// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces a signed frequency-offset word, in parts per million of the nominal frequency, that traces a triangle over time. The word is meant to steer the feedback divider of a PLL so that the synthesized clock sweeps across a small band, which spreads its spectral energy and lowers EMI. The triangle starts at its top point, walks down in equal position steps to its lowest point, and walks back up. One full excursion, down and back up, is one modulation period.

Two placements of the same triangle are supported. In centered placement the excursion is split evenly above and below the target frequency, so the target is also the average. In downward placement the top point sits exactly at the target and the whole excursion lies below it, for loads that must never see a clock above their rating. A 4-bit amplitude code sets the peak-to-peak excursion, and a rate select picks a slow modulation rate near 31 kHz or a fast one near 120 kHz. The step period is derived from the system clock frequency through parameters.

Placement, amplitude and rate are sampled when spreading is enabled and again each time a period completes, so a change never causes a jump in the middle of a sweep. With spreading off the offset is zero.

Top module: `ss_profile_gen`

## Requirements
- R1: While reset is asserted, and after it until spreading is enabled, freq_ofs_ppm is 0.
- R2: On the clock edge after spread_en is sampled low, freq_ofs_ppm becomes 0 and stays 0 whatever spread_down, rate_fast and amp_code do.
- R3: On the first clock edge with spread_en high after it was low, freq_ofs_ppm takes the top point of the profile (position 0) for the settings present at that edge.
- R4: The position advances once every DIV clock edges, with DIV = round(SYS_CLK_HZ / (rate * 2 * 2^STEPS_LOG2)); rate_fast = 0 selects SLOW_HZ (DIV = 25 at defaults) and rate_fast = 1 selects FAST_HZ (DIV = 7 at defaults). After enable, position n is shown from clock edge n*DIV after the enabling edge.
- R5: The position counts 0, 1, ..., S up to S = 2^STEPS_LOG2 (64 at defaults), then back down to 0, so one modulation period is 2*S steps.
- R6: With spread_down = 1 the offset at position p is -floor(span*p/S), where span = (amp_code+1)*UNIT_PPM (UNIT_PPM = 2500 ppm, so code 15 gives 4.0 %).
- R7: With spread_down = 0 the offset at position p is span/2 - floor(span*p/S), giving +span/2 at the top and -span/2 at the bottom (code 15 gives +/-2.0 %).
- R8: spread_down, amp_code and rate_fast are sampled at the enabling edge and at the edge where the position returns to 0; changes at any other time take effect only at the next such edge.
- R9: A code above CENTER_MAX_CODE in centered placement, or above DOWN_MAX_CODE in downward placement, is treated as that maximum.
- R10: In downward placement the offset is never above 0, and in any placement it stays within -(2^CODE_W)*UNIT_PPM to +(2^CODE_W)*UNIT_PPM/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spread_en | input | 1 | 1 enables modulation, 0 forces the offset to zero |
| spread_down | input | 1 | Placement: 0 centered, 1 downward |
| rate_fast | input | 1 | Modulation rate: 0 slow (about 31 kHz), 1 fast (about 120 kHz) |
| amp_code | input | CODE_W (4) | Peak-to-peak span in units of UNIT_PPM, minus one |
| freq_ofs_ppm | output | OFS_W (18) | Signed frequency offset in ppm |

## Verification
On every cycle the assertions check that a disabled block outputs zero, that the offset only moves on a step tick, that settings change only where the position is back at zero, that the position never overruns its top, and that the downward placement never rises above the target. The exact offset values of both placements, the step spacing at each rate, the deferral of a mid-period settings change to the next period boundary, the restart at the top point after re-enable and the amplitude clamp on a reduced-limit instance are shown only by the bench's directed scenarios, which compare every step of whole periods against values computed from the formulas.

// File: rtl/ss_profile_pkg.sv
package ss_profile_pkg;

    localparam int CODE_W = 4;

    typedef enum logic {
        PLACE_CENTER = 1'b0,
        PLACE_DOWN   = 1'b1
    } place_e;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Settings held for one modulation period
    typedef struct packed {
        place_e            place;
        rate_e             rate;
        logic [CODE_W-1:0] code;
    } prof_cfg_t;

    function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lim,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == lim - 1'b1) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ss_tri_walker.sv
module ss_tri_walker #(
    parameter int STEPS_LOG2 = 6,
    localparam int PW        = STEPS_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [PW-1:0] pos_q_o,
    output logic [PW-1:0] pos_d_o,
    output logic          wrap
);

    localparam logic [PW-1:0] BOTTOM_POS = PW'(2 ** STEPS_LOG2);

    typedef struct packed {
        logic          back;   // 1 while walking from the bottom back to the top
        logic [PW-1:0] pos;
    } walk_t;

    walk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (step) begin
            if (!st_q.back) begin
                st_d.pos = st_q.pos + 1'b1;
                if (st_d.pos == BOTTOM_POS) st_d.back = 1'b1;
            end else begin
                st_d.pos = st_q.pos - 1'b1;
                if (st_d.pos == '0) begin
                    st_d.back = 1'b0;
                    wrap      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_q_o = st_q.pos;
    assign pos_d_o = st_d.pos;

endmodule

// File: rtl/ss_ofs_map.sv
module ss_ofs_map
    import ss_profile_pkg::*;
#(
    parameter int STEPS_LOG2 = 6,
    parameter int UNIT_PPM   = 2500,
    parameter int OFS_W      = 18,
    localparam int PW        = STEPS_LOG2 + 1
) (
    input  prof_cfg_t                cfg,
    input  logic [PW-1:0]            pos,
    output logic signed [OFS_W-1:0]  ofs
);

    logic [31:0]        span;
    logic [31:0]        prod;
    logic [31:0]        scaled;
    logic signed [31:0] val;

    always_comb begin
        span   = (32'(cfg.code) + 32'd1) * 32'(UNIT_PPM);
        prod   = span * 32'(pos);
        scaled = prod >> STEPS_LOG2;
        if (cfg.place == PLACE_DOWN) val = -$signed(scaled);
        else                         val = $signed(span >> 1) - $signed(scaled);
        ofs = OFS_W'(val);
    end

endmodule

// File: rtl/ss_profile_gen.sv
module ss_profile_gen
    import ss_profile_pkg::*;
#(
    parameter int SYS_CLK_HZ      = 100_000_000,
    parameter int SLOW_HZ         = 31_250,
    parameter int FAST_HZ         = 120_000,
    parameter int STEPS_LOG2      = 6,
    parameter int UNIT_PPM        = 2500,
    parameter int CENTER_MAX_CODE = 15,
    parameter int DOWN_MAX_CODE   = 15,
    parameter int OFS_W           = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     spread_en,
    input  logic                     spread_down,
    input  logic                     rate_fast,
    input  logic [CODE_W-1:0]        amp_code,
    output logic signed [OFS_W-1:0]  freq_ofs_ppm
);

    localparam int STEPS    = 2 ** STEPS_LOG2;
    localparam int PW       = STEPS_LOG2 + 1;
    localparam int DIV_SLOW = int'(round_div(SYS_CLK_HZ, SLOW_HZ * 2 * STEPS));
    localparam int DIV_FAST = int'(round_div(SYS_CLK_HZ, FAST_HZ * 2 * STEPS));
    localparam int DIV_MAX  = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CNT_W    = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic             active;
        prof_cfg_t        cfg;
        logic [OFS_W-1:0] ofs;
    } gen_state_t;

    gen_state_t          st_d, st_q;
    prof_cfg_t           cfg_in;
    prof_cfg_t           cfg_nxt;
    logic [CODE_W-1:0]   code_lim;
    logic [CNT_W-1:0]    div_lim;
    logic                step_tick;
    logic                period_wrap;
    logic [PW-1:0]       walk_pos;
    logic [PW-1:0]       walk_pos_nxt;
    logic signed [OFS_W-1:0] map_ofs;

    // Sampled settings, with the amplitude clamped to the placement's limit
    always_comb begin
        code_lim      = spread_down ? CODE_W'(DOWN_MAX_CODE) : CODE_W'(CENTER_MAX_CODE);
        cfg_in.place  = spread_down ? PLACE_DOWN : PLACE_CENTER;
        cfg_in.rate   = rate_fast ? RATE_FAST : RATE_SLOW;
        cfg_in.code   = (amp_code > code_lim) ? code_lim : amp_code;
        cfg_nxt       = (!st_q.active || period_wrap) ? cfg_in : st_q.cfg;
    end

    assign div_lim = (st_q.cfg.rate == RATE_FAST) ? CNT_W'(DIV_FAST) : CNT_W'(DIV_SLOW);

    ss_step_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.active && spread_en),
        .lim   (div_lim),
        .tick  (step_tick)
    );

    ss_tri_walker #(
        .STEPS_LOG2 (STEPS_LOG2)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!spread_en),
        .step    (step_tick),
        .pos_q_o (walk_pos),
        .pos_d_o (walk_pos_nxt),
        .wrap    (period_wrap)
    );

    ss_ofs_map #(
        .STEPS_LOG2 (STEPS_LOG2),
        .UNIT_PPM   (UNIT_PPM),
        .OFS_W      (OFS_W)
    ) u_map (
        .cfg (cfg_nxt),
        .pos (walk_pos_nxt),
        .ofs (map_ofs)
    );

    always_comb begin
        st_d        = st_q;
        st_d.active = spread_en;
        st_d.cfg    = cfg_nxt;
        st_d.ofs    = spread_en ? map_ofs : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freq_ofs_ppm = st_q.ofs;

endmodule

// File: rtl/ss_profile_gen_chk.sv
module ss_profile_gen_chk #(
    parameter int OFS_W    = 18,
    parameter int PW       = 7,
    parameter int CFG_W    = 6,
    parameter int MAX_SPAN = 40000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    spread_en,
    input logic signed [OFS_W-1:0] ofs,
    input logic                    active,
    input logic                    tick,
    input logic [PW-1:0]           pos,
    input logic [CFG_W-1:0]        cfg,
    input logic                    place_down
);

    localparam logic [PW-1:0] BOTTOM_POS = PW'(2 ** (PW - 1));

    // R2
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> (ofs == '0));

    // R4
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && active && !tick) |=> $stable(ofs));

    // R8
    cfg_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && active) |=> ($stable(cfg) || pos == '0));

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= BOTTOM_POS);

    // R10
    down_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        place_down |-> (ofs <= 0));

    // R10
    ofs_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ofs) >= -MAX_SPAN) && (int'(ofs) <= MAX_SPAN / 2));

endmodule

bind ss_profile_gen ss_profile_gen_chk #(
    .OFS_W    (OFS_W),
    .PW       (PW),
    .CFG_W    ($bits(ss_profile_pkg::prof_cfg_t)),
    .MAX_SPAN ((2 ** ss_profile_pkg::CODE_W) * UNIT_PPM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spread_en  (spread_en),
    .ofs        (freq_ofs_ppm),
    .active     (st_q.active),
    .tick       (step_tick),
    .pos        (walk_pos),
    .cfg        (st_q.cfg),
    .place_down (st_q.cfg.place == ss_profile_pkg::PLACE_DOWN)
);

// File: tb/ss_profile_gen_bench.sv
module ss_profile_gen_bench;

    localparam int DIV_S = 25;
    localparam int DIV_F = 7;
    localparam int S     = 64;
    localparam int UNIT  = 2500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        dn = 1'b0;
    logic        fast = 1'b0;
    logic [3:0]  code = 4'd0;
    logic signed [17:0] ofs;
    logic signed [17:0] ofs_lim;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ss_profile_gen u_ss_profile_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en    (en),
        .spread_down  (dn),
        .rate_fast    (fast),
        .amp_code     (code),
        .freq_ofs_ppm (ofs)
    );

    ss_profile_gen #(
        .CENTER_MAX_CODE (7)
    ) u_ss_profile_gen_lim (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en    (en),
        .spread_down  (dn),
        .rate_fast    (fast),
        .amp_code     (code),
        .freq_ofs_ppm (ofs_lim)
    );

    function automatic int exp_ofs(input logic down, input int c, input int n);
        int p;
        int span;
        p = n % (2 * S);
        if (p > S) p = 2 * S - p;
        span = (c + 1) * UNIT;
        if (down) return -((span * p) / S);
        return span / 2 - (span * p) / S;
    endfunction

    task automatic check(input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // Enable with the given settings; returns 1 ns after the enabling edge
    task automatic go(input logic d, input int c, input logic f);
        @(negedge clk);
        dn = d; code = 4'(c); fast = f; en = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic walk(input int from, input int upto, input int div,
                        input logic d, input int c, input string tag);
        for (int n = from; n <= upto; n++) begin
            repeat (div) @(posedge clk);
            #1;
            check(int'(ofs), exp_ofs(d, c, n), $sformatf("%s step %0d", tag, n));
        end
    endtask

    task automatic halt();
        @(negedge clk);
        en = 1'b0;
        @(posedge clk); #1;
        check(int'(ofs), 0, "R2 zero after disable");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(int'(ofs), 0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(int'(ofs), 0, "R1 after reset, disabled");
    endtask

    task automatic t_idle_ignored();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dn = i[0]; fast = i[1]; code = 4'(i * 3);
            @(posedge clk); #1;
            check(int'(ofs), 0, "R2 inputs ignored while disabled");
        end
    endtask

    task automatic t_down_full();
        go(1'b1, 15, 1'b0);
        check(int'(ofs), 0, "R3 down top point");
        walk(1, 2 * S, DIV_S, 1'b1, 15, "R6 R5 down code15 slow");
        halt();
    endtask

    task automatic t_center_full();
        go(1'b0, 15, 1'b0);
        check(int'(ofs), 20000, "R3 center top point");
        walk(1, 2 * S, DIV_S, 1'b0, 15, "R7 R5 center code15 slow");
        halt();
    endtask

    task automatic t_fast_small();
        go(1'b0, 0, 1'b1);
        check(int'(ofs), 1250, "R7 center code0 top");
        walk(1, 2 * S + 4, DIV_F, 1'b0, 0, "R4 center code0 fast");
        halt();
    endtask

    task automatic t_mid_change();
        go(1'b1, 3, 1'b0);
        walk(1, 10, DIV_S, 1'b1, 3, "R6 down code3");
        @(negedge clk);
        dn = 1'b0; code = 4'd7; fast = 1'b1;
        #1;
        walk(11, 2 * S - 1, DIV_S, 1'b1, 3, "R8 old settings kept mid-period");
        walk(2 * S, 2 * S, DIV_S, 1'b0, 7, "R8 new settings at boundary");
        walk(2 * S + 1, 2 * S + 12, DIV_F, 1'b0, 7, "R8 R4 new rate after boundary");
    endtask

    task automatic t_disable_reenable();
        @(negedge clk);
        en = 1'b0; code = 4'd2;
        @(posedge clk); #1;
        check(int'(ofs), 0, "R2 zero one edge after disable");
        repeat (3) @(posedge clk);
        #1;
        check(int'(ofs), 0, "R2 stays zero");
        go(1'b0, 5, 1'b1);
        check(int'(ofs), 7500, "R3 restart at top after re-enable");
        walk(1, 3, DIV_F, 1'b0, 5, "R3 R4 restart steps");
        halt();
    endtask

    task automatic t_clamp();
        go(1'b0, 12, 1'b0);
        check(int'(ofs), 16250, "R7 center code12 top");
        check(int'(ofs_lim), 10000, "R9 center clamp top");
        repeat (S * DIV_S) @(posedge clk);
        #1;
        check(int'(ofs), -16250, "R7 center code12 bottom");
        check(int'(ofs_lim), -10000, "R9 center clamp bottom");
        halt();
        go(1'b1, 12, 1'b1);
        repeat (S * DIV_F) @(posedge clk);
        #1;
        check(int'(ofs_lim), -32500, "R9 down not clamped by center limit");
        check(int'(ofs), -32500, "R6 down code12 bottom");
        halt();
    endtask

    initial begin
        t_reset();
        t_idle_ignored();
        t_down_full();
        t_center_full();
        t_fast_small();
        t_mid_change();
        t_disable_reenable();
        t_clamp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule